// File: doc/BRIEF.md
# Legacy VGA Address Router

This block sits on the outbound request path of a host bridge. It inspects every request's address and space type and decides whether the request falls into one of the fixed legacy display compatibility windows. There is one window in memory space and two in I/O space. A request that falls into a window is steered by a single enable bit. With the bit clear, the request stays on the PCI side. With the bit set, it goes to the HyperTransport fabric, and its compatibility flag is forced low.

The enable bit lives in a small control register inside the block. The register is loaded through a write strobe and can be read back. The readback also reports an alias-forwarding enable that is not supported, and that enable always reads as zero. The routing decision is registered, so it appears one cycle after the request together with an output valid, a hit indication and the outgoing compatibility flag.

Top module: `vga_route_top`

## Requirements
- R1: A memory request (`req_is_io`=0) hits when its full 24-bit address lies in 0x0A0000..0x0BFFFF inclusive. Any set bit above bit 19 outside that range makes it a miss.
- R2: An I/O request (`req_is_io`=1) hits when address bits [9:0] lie in 0x3B0..0x3BB or 0x3C0..0x3DF inclusive. Address bits above bit 9 are ignored.
- R3: The space type selects the decode. An I/O request whose address is inside the memory window, or a memory request whose address is inside an I/O window, does not hit unless it also matches its own space's window.
- R4: With the enable readback at 0, a hit is routed to PCI (`rsp_route`=0) and `rsp_compat` equals the request's `req_compat`.
- R5: With the enable readback at 1, a hit is routed to the fabric (`rsp_route`=1) and `rsp_compat` is 0 whatever `req_compat` was.
- R6: A miss gives `rsp_vga_hit`=0 and `rsp_route`=0 (PCI), and passes `req_compat` through, whatever the enable value.
- R7: A request sampled with `req_valid`=1 at a clock edge produces `rsp_valid`=1 and its result right after that edge. After an edge with `req_valid`=0, `rsp_valid`, `rsp_route`, `rsp_compat` and `rsp_vga_hit` are all 0.
- R8: The enable readback `cfg_vga_en_q` is 0 after reset and takes `cfg_vga_en_d` at an edge where `cfg_wr`=1. A request sampled at that same edge uses the previous enable value.
- R9: The alias-forwarding enable readback `cfg_isa_en_q` always reads 0.
- R10: During and right after reset, `rsp_valid` is 0 and the response fields are at their defaults of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the enable register |
| cfg_vga_en_d | input | 1 | New enable value |
| cfg_vga_en_q | output | 1 | Enable register readback |
| cfg_isa_en_q | output | 1 | Alias-forwarding enable readback, constant 0 |
| req_valid | input | 1 | Request valid |
| req_addr | input | 24 | Request address |
| req_is_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_compat | input | 1 | Compatibility flag carried by the request |
| rsp_valid | output | 1 | Registered result valid |
| rsp_route | output | 1 | 0 = PCI, 1 = fabric |
| rsp_compat | output | 1 | Outgoing compatibility flag |
| rsp_vga_hit | output | 1 | Request hit a legacy window |

## Verification
The bench tests each window edge on both sides: one below the base, the base, the limit and one above the limit. A comparison that is off by one, or that uses < where <= is needed, shows up as a wrong hit bit at those addresses. It sends memory-window addresses as I/O requests, and I/O-window addresses as memory requests. A decoder that ignores the space type would then report hits. It sets high address bits on I/O requests, which a decoder that compares too many bits would wrongly reject. It sets the same high bits on memory requests, which a decoder that compares too few bits would wrongly accept. Requests that carry the compatibility flag go to the fabric, where a design that does not force the flag low would forward it. A write and a request fall on the same edge, and a design that bypasses the enable register would route that request by the new value.

// File: rtl/vga_route_pkg.sv
package vga_route_pkg;

   typedef enum logic {
      ROUTE_PCI    = 1'b0,
      ROUTE_FABRIC = 1'b1
   } route_e;

   typedef struct packed {
      logic   valid;
      route_e route;
      logic   compat;
      logic   hit;
   } route_rec_t;

   localparam route_rec_t ROUTE_REC_IDLE = '{valid: 1'b0, route: ROUTE_PCI,
                                             compat: 1'b0, hit: 1'b0};

endpackage

// File: rtl/vga_mem_window.sv
module vga_mem_window #(
   parameter int              ADDR_W = 24,
   parameter logic [ADDR_W-1:0] BASE = 'h0A0000,
   parameter logic [ADDR_W-1:0] LIMIT = 'h0BFFFF
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              is_io,
   output logic              hit
);

   if (LIMIT < BASE) begin : g_bad_range
      $error("vga_mem_window: LIMIT below BASE");
   end

   logic above_base;
   logic below_limit;

   assign above_base  = (addr >= BASE);
   assign below_limit = (addr <= LIMIT);
   assign hit         = !is_io && above_base && below_limit;

endmodule

// File: rtl/vga_io_window.sv
module vga_io_window #(
   parameter int                       IO_W    = 10,
   parameter int                       NUM_WIN = 2,
   parameter logic [NUM_WIN*IO_W-1:0]  LO_VEC  = {10'h3C0, 10'h3B0},
   parameter logic [NUM_WIN*IO_W-1:0]  HI_VEC  = {10'h3DF, 10'h3BB}
) (
   input  logic [IO_W-1:0] io_addr,
   input  logic            is_io,
   output logic            hit
);

   if (NUM_WIN < 1) begin : g_bad_count
      $error("vga_io_window: NUM_WIN must be at least 1");
   end

   logic [NUM_WIN-1:0] win_hit;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      localparam logic [IO_W-1:0] LO = LO_VEC[w*IO_W +: IO_W];
      localparam logic [IO_W-1:0] HI = HI_VEC[w*IO_W +: IO_W];

      if (HI < LO) begin : g_bad_win
         $error("vga_io_window: window limit below base");
      end

      assign win_hit[w] = (io_addr >= LO) && (io_addr <= HI);
   end

   assign hit = is_io && (|win_hit);

endmodule

// File: rtl/vga_route_reg.sv
module vga_route_reg
   import vga_route_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  route_rec_t d,
   output route_rec_t q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= ROUTE_REC_IDLE;
      end else if (d.valid) begin
         q <= d;
      end else begin
         q <= ROUTE_REC_IDLE;
      end
   end

   // R7
   idle_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !d.valid |=> (q == ROUTE_REC_IDLE));

   // R7
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      d.valid |=> q.valid);

endmodule

// File: rtl/vga_route_top.sv
module vga_route_top
   import vga_route_pkg::*;
#(
   parameter int                       ADDR_W     = 24,
   parameter int                       IO_W       = 10,
   parameter logic [ADDR_W-1:0]        MEM_BASE   = 'h0A0000,
   parameter logic [ADDR_W-1:0]        MEM_LIMIT  = 'h0BFFFF,
   parameter int                       NUM_IO_WIN = 2,
   parameter logic [NUM_IO_WIN*IO_W-1:0] IO_LO_VEC = {10'h3C0, 10'h3B0},
   parameter logic [NUM_IO_WIN*IO_W-1:0] IO_HI_VEC = {10'h3DF, 10'h3BB}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              cfg_vga_en_d,
   output logic              cfg_vga_en_q,
   output logic              cfg_isa_en_q,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_is_io,
   input  logic              req_compat,
   output logic              rsp_valid,
   output logic              rsp_route,
   output logic              rsp_compat,
   output logic              rsp_vga_hit
);

   if (IO_W > ADDR_W) begin : g_bad_io_w
      $error("vga_route_top: IO_W wider than ADDR_W");
   end
   if (ADDR_W < 20) begin : g_bad_addr_w
      $error("vga_route_top: ADDR_W too narrow for the memory window");
   end

   // enable register
   logic vga_en_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vga_en_r <= 1'b0;
      end else if (cfg_wr) begin
         vga_en_r <= cfg_vga_en_d;
      end
   end

   assign cfg_vga_en_q = vga_en_r;
   assign cfg_isa_en_q = 1'b0;

   // window decode
   logic mem_hit;
   logic io_hit;
   logic any_hit;
   logic fwd_fabric;

   vga_mem_window #(
      .ADDR_W (ADDR_W),
      .BASE   (MEM_BASE),
      .LIMIT  (MEM_LIMIT)
   ) u_mem_win (
      .addr   (req_addr),
      .is_io  (req_is_io),
      .hit    (mem_hit)
   );

   vga_io_window #(
      .IO_W    (IO_W),
      .NUM_WIN (NUM_IO_WIN),
      .LO_VEC  (IO_LO_VEC),
      .HI_VEC  (IO_HI_VEC)
   ) u_io_win (
      .io_addr (req_addr[IO_W-1:0]),
      .is_io   (req_is_io),
      .hit     (io_hit)
   );

   assign any_hit    = mem_hit | io_hit;
   assign fwd_fabric = any_hit & vga_en_r;

   // route decision and output register
   route_rec_t nxt;
   route_rec_t cur;

   always_comb begin
      nxt.valid  = req_valid;
      nxt.hit    = any_hit;
      nxt.route  = fwd_fabric ? ROUTE_FABRIC : ROUTE_PCI;
      nxt.compat = fwd_fabric ? 1'b0 : req_compat;
   end

   vga_route_reg u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (nxt),
      .q     (cur)
   );

   assign rsp_valid   = cur.valid;
   assign rsp_route   = cur.route;
   assign rsp_compat  = cur.compat;
   assign rsp_vga_hit = cur.hit;

   // R5
   fabric_compat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_route) |-> !rsp_compat);

   // R6
   miss_goes_pci_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_vga_hit) |-> !rsp_route);

   // R4
   disabled_pci_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !cfg_vga_en_q) |=> !rsp_route);

   // R8
   cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (cfg_vga_en_q == $past(cfg_vga_en_d)));

   // R8
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr |=> $stable(cfg_vga_en_q));

endmodule

// File: tb/tb_vga_route_top.sv
`timescale 1ns/1ps
module tb_vga_route_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_wr;
   logic        cfg_vga_en_d;
   logic        cfg_vga_en_q;
   logic        cfg_isa_en_q;
   logic        req_valid;
   logic [23:0] req_addr;
   logic        req_is_io;
   logic        req_compat;
   logic        rsp_valid;
   logic        rsp_route;
   logic        rsp_compat;
   logic        rsp_vga_hit;

   int checks = 0;
   int errors = 0;
   bit en_model = 1'b0;

   always #2.5 clk = ~clk;

   vga_route_top dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_wr       (cfg_wr),
      .cfg_vga_en_d (cfg_vga_en_d),
      .cfg_vga_en_q (cfg_vga_en_q),
      .cfg_isa_en_q (cfg_isa_en_q),
      .req_valid    (req_valid),
      .req_addr     (req_addr),
      .req_is_io    (req_is_io),
      .req_compat   (req_compat),
      .rsp_valid    (rsp_valid),
      .rsp_route    (rsp_route),
      .rsp_compat   (rsp_compat),
      .rsp_vga_hit  (rsp_vga_hit)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic bit ref_hit(input logic [23:0] a, input bit io);
      if (io)
         return (a[9:0] >= 10'h3B0 && a[9:0] <= 10'h3BB) ||
                (a[9:0] >= 10'h3C0 && a[9:0] <= 10'h3DF);
      return (a >= 24'h0A0000 && a <= 24'h0BFFFF);
   endfunction

   task automatic write_en(input bit v);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_vga_en_d = v;
      @(negedge clk);
      cfg_wr = 1'b0;
      en_model = v;
   endtask

   // one request, checked at the negedge after its capture edge
   task automatic send(input string req, input logic [23:0] a, input bit io, input bit cp);
      bit h, f;
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_is_io = io; req_compat = cp;
      @(negedge clk);
      req_valid = 1'b0;
      h = ref_hit(a, io);
      f = h && en_model;
      chk(req, "valid", rsp_valid, 1);
      chk(req, $sformatf("hit @%0h io=%0d", a, io), rsp_vga_hit, h);
      chk(req, $sformatf("route @%0h", a), rsp_route, f);
      chk(req, $sformatf("compat @%0h", a), rsp_compat, f ? 1'b0 : cp);
   endtask

   task automatic t_reset;
      // R10 R8 R9
      chk("R10", "rsp_valid reset", rsp_valid, 0);
      chk("R10", "rsp_route reset", rsp_route, 0);
      chk("R10", "rsp_vga_hit reset", rsp_vga_hit, 0);
      chk("R10", "rsp_compat reset", rsp_compat, 0);
      chk("R8", "enable reset", cfg_vga_en_q, 0);
      chk("R9", "isa reset", cfg_isa_en_q, 0);
   endtask

   task automatic t_mem_window;
      // R1 edges and upper bits
      send("R1", 24'h09FFFF, 0, 0);
      send("R1", 24'h0A0000, 0, 0);
      send("R1", 24'h0B1234, 0, 1);
      send("R1", 24'h0BFFFF, 0, 0);
      send("R1", 24'h0C0000, 0, 0);
      send("R1", 24'h1A0000, 0, 0);
      send("R1", 24'h8B0000, 0, 0);
   endtask

   task automatic t_io_window;
      // R2 edges, gap and ignored high bits
      send("R2", 24'h0003AF, 1, 0);
      send("R2", 24'h0003B0, 1, 0);
      send("R2", 24'h0003BB, 1, 0);
      send("R2", 24'h0003BC, 1, 0);
      send("R2", 24'h0003BF, 1, 0);
      send("R2", 24'h0003C0, 1, 0);
      send("R2", 24'h0003DF, 1, 0);
      send("R2", 24'h0003E0, 1, 0);
      send("R2", 24'hFFFFB5, 1, 0);
      send("R2", 24'h12F3D0, 1, 1);
   endtask

   task automatic t_space;
      // R3 wrong space
      send("R3", 24'h0A0000, 1, 0);
      send("R3", 24'h0B0100, 1, 0);
      send("R3", 24'h0003C0, 0, 0);
      send("R3", 24'h0003B5, 0, 0);
   endtask

   task automatic t_enable_off;
      // R4 hits stay on PCI, compat passes
      write_en(0);
      send("R4", 24'h0A8000, 0, 1);
      send("R4", 24'h0003C4, 1, 1);
      send("R4", 24'h0003B2, 1, 0);
   endtask

   task automatic t_enable_on;
      // R5 hits to fabric with compat forced low
      write_en(1);
      chk("R8", "enable readback", cfg_vga_en_q, 1);
      chk("R9", "isa readback", cfg_isa_en_q, 0);
      send("R5", 24'h0A0000, 0, 1);
      send("R5", 24'h0BFFFF, 0, 0);
      send("R5", 24'h0003DF, 1, 1);
      send("R5", 24'hABC3B0, 1, 1);
   endtask

   task automatic t_miss;
      // R6 misses stay on PCI under either enable value
      write_en(1);
      send("R6", 24'h0C0000, 0, 1);
      send("R6", 24'h0003E0, 1, 1);
      send("R6", 24'h000000, 0, 0);
      write_en(0);
      send("R6", 24'h0003AF, 1, 1);
   endtask

   task automatic t_timing;
      // R7 back-to-back then idle
      write_en(1);
      @(negedge clk);
      req_valid = 1'b1; req_addr = 24'h0A0004; req_is_io = 1'b0; req_compat = 1'b1;
      @(negedge clk);
      chk("R7", "first valid", rsp_valid, 1);
      chk("R7", "first route", rsp_route, 1);
      chk("R7", "first compat", rsp_compat, 0);
      req_addr = 24'h0003E1; req_is_io = 1'b1; req_compat = 1'b1;
      @(negedge clk);
      chk("R7", "second valid", rsp_valid, 1);
      chk("R7", "second route", rsp_route, 0);
      chk("R7", "second hit", rsp_vga_hit, 0);
      chk("R7", "second compat", rsp_compat, 1);
      req_valid = 1'b0; req_addr = 24'h0A0000; req_is_io = 1'b0;
      @(negedge clk);
      chk("R7", "idle valid", rsp_valid, 0);
      chk("R7", "idle route", rsp_route, 0);
      chk("R7", "idle hit", rsp_vga_hit, 0);
      chk("R7", "idle compat", rsp_compat, 0);
   endtask

   task automatic t_cfg_same_edge;
      // R8 a request at the write edge sees the old value
      write_en(0);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_vga_en_d = 1'b1;
      req_valid = 1'b1; req_addr = 24'h0003C8; req_is_io = 1'b1; req_compat = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0; req_valid = 1'b0;
      en_model = 1'b1;
      chk("R8", "same-edge route", rsp_route, 0);
      chk("R8", "same-edge compat", rsp_compat, 1);
      chk("R8", "enable after write", cfg_vga_en_q, 1);
      chk("R9", "isa after write", cfg_isa_en_q, 0);
      send("R8", 24'h0003C8, 1, 1);
      @(negedge clk);
      chk("R8", "enable held", cfg_vga_en_q, 1);
   endtask

   initial begin
      rst_n = 1'b0; cfg_wr = 1'b0; cfg_vga_en_d = 1'b0;
      req_valid = 1'b0; req_addr = '0; req_is_io = 1'b0; req_compat = 1'b0;
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_mem_window;
      t_io_window;
      t_space;
      t_enable_off;
      t_enable_on;
      t_miss;
      t_timing;
      t_cfg_same_edge;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule